// File: doc/BRIEF.md
# Three-Bit Dual-Order Step Counter

This block is a three-bit synchronous counter whose state is held in three D-type storage bits. Each bit's next value is produced by a per-bit combinational equation on the present state, so the successor depends on nothing but the current count and the control inputs. Two stepping orders are offered.

The first order is ordinary binary counting that wraps from 7 back to 0. The second order visits the eight codes in the fixed loop 0, 2, 3, 1, 4, 5, 7, 6 and then returns to 0. The `mode` input picks the order on every clock edge.

A parallel-load path puts any three-bit value into the counter at the next rising edge. A two-way selector in front of each storage bit does this, with `load` as the select. Loading takes priority over stepping and holding. A synchronous active-low reset takes priority over everything.

Top module: `tri_step_counter`

## Requirements
- R1: While `rst_n` is 0 at a rising edge of `clk`, `q` becomes 0 at that edge, whatever the other inputs are.
- R2: With `rst_n`=1, `load`=0 and `enable`=0, `q` keeps its value across the edge.
- R3: With `rst_n`=1, `load`=0, `enable`=1 and `mode`=0 (binary order), `q` becomes (`q`+1) modulo 8. After 7 it becomes 0.
- R4: With `rst_n`=1, `load`=0, `enable`=1 and `mode`=1 (loop order), `q` follows these successors: 0→2, 2→3, 3→1, 1→4, 4→5, 5→7, 7→6, 6→0.
- R5: With `rst_n`=1 and `load`=1, `q` takes `load_val` at the next edge, regardless of `enable` and `mode`.
- R6: When `mode` changes between two steps, the next step applies the new mode's successor rule to the current `q`. Nothing else is affected.
- R7: After a load, later steps continue from the loaded value in whichever order `mode` selects.
- R8: `q` changes only at a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the count |
| enable | input | 1 | Step enable; when 0 and no load is requested, the count holds |
| mode | input | 1 | Order select: 0 = binary, 1 = loop order 0,2,3,1,4,5,7,6 |
| load | input | 1 | Parallel-load request; takes priority over stepping |
| load_val | input | 3 | Value loaded when `load` is 1 |
| q | output | 3 | Current count |

## Verification
The bench walks a full eight-step loop in each order and compares every step with a successor table. A fault in any one bit equation therefore shows up as a wrong code at a specific position in the loop. Loads are issued with `enable` low and with both values of `mode`, followed by further stepping. A load that was gated by enable, or one that lost its priority, would leave the old count or take a step instead. `mode` is also flipped mid-count, including at codes where the two orders disagree, which catches a design that latches the mode or lags it by a cycle. Reset is asserted together with `load` to confirm that clearing wins.

// File: rtl/tsc_pkg.sv
// Package: shared width and step-order type for the three-bit step counter.
// Assumes the count is exactly three bits wide; the bit equations depend on it.
package tsc_pkg;
    localparam int CNT_W  = 3;
    localparam int N_CODE = 1 << CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        ORD_BINARY = 1'b0,
        ORD_LOOP   = 1'b1
    } order_e;
endpackage

// File: rtl/tsc_next_bin.sv
// Module: binary successor of the present count, one equation per bit.
// Assumes a three-bit count; 7 is followed by 0.
module tsc_next_bin
    import tsc_pkg::*;
(
    input  cnt_t cur,
    output cnt_t nxt
);
    // Per-bit next-value equations for plain binary counting.
    always_comb begin
        nxt[0] = ~cur[0];
        nxt[1] = cur[1] ^ cur[0];
        nxt[2] = (cur[2] & ~cur[1]) | (cur[2] & ~cur[0]) | (~cur[2] & cur[1] & cur[0]);
    end
endmodule

// File: rtl/tsc_next_loop.sv
// Module: successor in the loop order 0,2,3,1,4,5,7,6, one equation per bit.
// Assumes a three-bit count; every code has exactly one successor.
module tsc_next_loop
    import tsc_pkg::*;
(
    input  cnt_t cur,
    output cnt_t nxt
);
    // Per-bit next-value equations derived from the loop successor map.
    always_comb begin
        nxt[0] = cur[2] ^ cur[1];
        nxt[1] = ~(cur[2] ^ cur[0]);
        nxt[2] = (~cur[1] & cur[0]) | (cur[2] & ~cur[1]) | (cur[2] & cur[0]);
    end
endmodule

// File: rtl/tsc_bit_sel.sv
// Module: a two-way selector per state bit, choosing the load value or the step value.
// Assumes sel is a single control shared by all bits.
module tsc_bit_sel #(
    parameter int W = 3
) (
    input  logic         sel,
    input  logic [W-1:0] when_hi,
    input  logic [W-1:0] when_lo,
    output logic [W-1:0] out
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            // Choose this bit's source from the select line.
            assign out[b] = sel ? when_hi[b] : when_lo[b];
        end
    endgenerate
endmodule

// File: rtl/tri_step_counter.sv
// Module: three-bit counter with binary or loop stepping order and a parallel load.
// Priority order: synchronous reset, then load, then enable (step), else hold.
// Assumes rst_n is synchronous to clk.
module tri_step_counter
    import tsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] q
);
    cnt_t   state_r;
    cnt_t   succ_bin;
    cnt_t   succ_loop;
    cnt_t   succ_sel;
    cnt_t   step_or_hold;
    cnt_t   d_in;
    order_e order;

    assign order = order_e'(mode);

    tsc_next_bin u_bin (
        .cur (state_r),
        .nxt (succ_bin)
    );

    tsc_next_loop u_loop (
        .cur (state_r),
        .nxt (succ_loop)
    );

    // Pick the successor for the current order.
    tsc_bit_sel #(.W(CNT_W)) u_ord_sel (
        .sel     (order == ORD_LOOP),
        .when_hi (succ_loop),
        .when_lo (succ_bin),
        .out     (succ_sel)
    );

    // Hold the count unless stepping is enabled.
    tsc_bit_sel #(.W(CNT_W)) u_en_sel (
        .sel     (enable),
        .when_hi (succ_sel),
        .when_lo (state_r),
        .out     (step_or_hold)
    );

    // The load selector sits directly in front of each D input.
    tsc_bit_sel #(.W(CNT_W)) u_ld_sel (
        .sel     (load),
        .when_hi (load_val),
        .when_lo (step_or_hold),
        .out     (d_in)
    );

    // State register: updated only at the rising clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) state_r <= '0;
        else        state_r <= d_in;
    end

    assign q = state_r;
endmodule

// File: rtl/tri_step_counter_chk.sv
// Module: property checker for tri_step_counter, attached by bind.
// Assumes it sees the top-level ports only.
module tri_step_counter_chk
    import tsc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             mode,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] q
);
    // Loop-order successor as a lookup table, independent of the bit equations.
    function automatic logic [CNT_W-1:0] loop_succ(input logic [CNT_W-1:0] c);
        case (c)
            3'd0: loop_succ = 3'd2;
            3'd2: loop_succ = 3'd3;
            3'd3: loop_succ = 3'd1;
            3'd1: loop_succ = 3'd4;
            3'd4: loop_succ = 3'd5;
            3'd5: loop_succ = 3'd7;
            3'd7: loop_succ = 3'd6;
            default: loop_succ = 3'd0;
        endcase
    endfunction

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !enable) |=> $stable(q));

    a_r3_binary_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && enable && !mode) |=> (q == CNT_W'($past(q) + 1'b1)));

    a_r4_loop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && enable && mode) |=> (q == loop_succ($past(q))));

    a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));
endmodule

bind tri_step_counter tri_step_counter_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .mode     (mode),
    .load     (load),
    .load_val (load_val),
    .q        (q)
);

// File: tb/test_tri_step_counter.sv
// Directed bench for tri_step_counter: one task per scenario, each checking its own results.
module test_tri_step_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode = 1'b0;
    logic       load = 1'b0;
    logic [2:0] load_val = 3'd0;
    logic [2:0] q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tri_step_counter i_tri_step_counter (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .load(load), .load_val(load_val), .q(q)
    );

    // Reference successor table written from the requirements.
    function automatic logic [2:0] ref_next(input logic m, input logic [2:0] c);
        if (!m) return c + 3'd1;
        case (c)
            3'd0: return 3'd2;
            3'd2: return 3'd3;
            3'd3: return 3'd1;
            3'd1: return 3'd4;
            3'd4: return 3'd5;
            3'd5: return 3'd7;
            3'd7: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_bad++;
            $display("FAIL %s: q=%0d expected %0d", req, q, exp);
        end
    endtask

    // Apply inputs after a falling edge, let one rising edge pass, sample 1 ns later.
    task automatic cycle(input logic r, input logic e, input logic m, input logic l, input logic [2:0] v);
        @(negedge clk);
        rst_n = r; enable = e; mode = m; load = l; load_val = v;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 3'd0);
        check("R1 reset", 3'd0);
    endtask

    task automatic t_binary_loop();
        logic [2:0] exp = q;
        for (int i = 0; i < 8; i++) begin
            exp = ref_next(1'b0, exp);
            cycle(1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
            check("R3 binary step", exp);
        end
    endtask

    task automatic t_loop_order();
        logic [2:0] exp = q;
        for (int i = 0; i < 8; i++) begin
            exp = ref_next(1'b1, exp);
            cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'd0);
            check("R4 loop step", exp);
        end
    endtask

    task automatic t_hold();
        logic [2:0] keep = q;
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 3'd6);
        check("R2 hold binary", keep);
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 3'd1);
        check("R2 hold loop", keep);
        #1;
        check("R8 stable between edges", keep);
    endtask

    task automatic t_load_then_step();
        logic [2:0] exp;
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 3'd5);
        check("R5 load with enable low", 3'd5);
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 3'd3);
        check("R5 load over loop step", 3'd3);
        exp = 3'd3;
        for (int i = 0; i < 3; i++) begin
            exp = ref_next(1'b1, exp);
            cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'd0);
            check("R7 loop after load", exp);
        end
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 3'd7);
        check("R5 load over binary step", 3'd7);
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
        check("R7 binary wrap after load", 3'd0);
    endtask

    task automatic t_mode_switch();
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 3'd1);
        check("R6 setup", 3'd1);
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'd0);
        check("R6 loop from 1", 3'd4);
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
        check("R6 binary from 4", 3'd5);
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'd0);
        check("R6 loop from 5", 3'd7);
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
        check("R6 binary from 7", 3'd0);
    endtask

    task automatic t_reset_over_load();
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 3'd6);
        check("R5 setup", 3'd6);
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 3'd5);
        check("R1 reset beats load", 3'd0);
    endtask

    initial begin
        t_reset();
        t_binary_loop();
        t_loop_order();
        t_hold();
        t_load_then_step();
        t_mode_switch();
        t_reset_over_load();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule